// File: doc/BRIEF.md
# Program RAM Boot Loader

This block fills a small program memory with instruction words that a host delivers one at a time, while the processing core it feeds is kept in soft reset. The host first writes a control word with both the boot request bit and the hold bit set. From then on every data word the host presents is cut down to its low instruction bits and stored at the next address, starting from address zero. The lowest addresses of this memory serve as the core's interrupt vectors, so a usable program always begins with the vector words and carries on from there without gaps.

When the host clears the hold bit, loading ends. The core is released and told to start fetching from address zero by a one-cycle completion pulse. From that point the core reads instructions through a registered fetch port. The loader reports how many words the current load has stored, whether the vector area is complete, and whether the host tried to write past the last address.

Top module: `prog_ram_loader`

## Requirements
- R1: After reset, the core is held (`core_run` low), loading is inactive, and `boot_done`, `overflow`, `fetch_valid` and `load_count` are all zero.
- R2: Loading becomes active on the cycle after a control write (`ctl_we`) with both `ctl_boot` and `ctl_srst` high. A control write with only one of the two bits high does not activate it. Each new activation resets `load_count` to 0.
- R3: While loading, each `wr_valid` word stores its low 20 bits, `wr_data[19:0]`, at address `load_count` and increments `load_count` by one, so consecutive words land at 0, 1, 2 and so on. Bits 23:20 are dropped.
- R4: While loading, a word presented when 128 words are already stored is discarded. It leaves memory and `load_count` (128) unchanged and sets `overflow`. `overflow` stays set until the next activation of loading clears it.
- R5: Data words presented while loading is inactive are ignored: memory contents and `load_count` do not change.
- R6: `vec_ready` is high exactly when the current load has stored at least 10 words, which covers the vector area at addresses 0 to 9.
- R7: A control write with `ctl_srst` low while loading is active ends loading. On the next cycle `boot_done` is high for exactly one cycle, `core_run` is high and loading is inactive. Releasing the hold bit when loading was not active gives no `boot_done` pulse.
- R8: While the core is held, a fetch request is not served: `fetch_valid` stays low and `fetch_data` stays zero.
- R9: While `core_run` is high, a fetch request at address A gives `fetch_valid` high one cycle later, with `fetch_data` equal to the 20-bit word stored at A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_boot | input | 1 | Boot request bit of the control word |
| ctl_srst | input | 1 | Core hold (soft reset) bit of the control word |
| wr_valid | input | 1 | Host data word valid |
| wr_data | input | 24 | Host data word; low 20 bits are the instruction |
| fetch_req | input | 1 | Core instruction fetch request |
| fetch_addr | input | 7 | Core fetch address |
| fetch_valid | output | 1 | Fetch data valid, one cycle after the request |
| fetch_data | output | 20 | Fetched instruction word |
| boot_active | output | 1 | Loading in progress |
| core_run | output | 1 | Core released from soft reset |
| boot_done | output | 1 | One-cycle pulse when loading ends and the core starts at address 0 |
| vec_ready | output | 1 | Vector area fully loaded |
| overflow | output | 1 | A word was offered beyond the last address |
| load_count | output | 8 | Words stored by the current load |

## Verification
The case hardest to reach from the ports is the full memory: the last address written, then further words refused, then the refused words proven never to have reached memory. The stimulus does a second, complete load of 130 distinct words over an earlier partial load. It checks the counter and the flag around words 128 and 129, releases the core, and reads back address 127 and a sample of lower addresses through the fetch port. Another load then confirms that the sticky flag is cleared. Ignored host words are proven harmless the same way, by fetching the affected addresses after the core is running.

// File: rtl/prog_ram_loader.sv
module prog_ram_loader #(
  parameter int DEPTH     = 128,
  parameter int XFER_W    = 24,
  parameter int INSTR_W   = 20,
  parameter int VEC_WORDS = 10,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic               ctl_boot,
  input  logic               ctl_srst,
  input  logic               wr_valid,
  input  logic [XFER_W-1:0]  wr_data,
  input  logic               fetch_req,
  input  logic [AW-1:0]      fetch_addr,
  output logic               fetch_valid,
  output logic [INSTR_W-1:0] fetch_data,
  output logic               boot_active,
  output logic               core_run,
  output logic               boot_done,
  output logic               vec_ready,
  output logic               overflow,
  output logic [CW-1:0]      load_count
);

  logic               boot_q, srst_q, done_q, ovf_q, fv_q;
  logic [CW-1:0]      ptr_q;
  logic [INSTR_W-1:0] fd_q;
  logic [INSTR_W-1:0] mem [DEPTH];
  logic               enter, wr_take, wr_full, serve;
  logic               unused_hi;

  assign boot_active = boot_q & srst_q;
  assign core_run    = ~srst_q;
  assign enter       = ctl_we & ctl_boot & ctl_srst & ~boot_active;
  assign wr_full     = (ptr_q == CW'(DEPTH));
  assign wr_take     = boot_active & wr_valid & ~wr_full;
  assign serve       = fetch_req & core_run;
  assign unused_hi   = ^wr_data[XFER_W-1:INSTR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b0;
      srst_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= ctl_we & ~ctl_srst & boot_active;
      if (ctl_we) begin
        boot_q <= ctl_boot;
        srst_q <= ctl_srst;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
    end else if (enter) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
    end else if (boot_active && wr_valid) begin
      if (wr_full) ovf_q <= 1'b1;
      else         ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_take) mem[ptr_q[AW-1:0]] <= wr_data[INSTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_q <= 1'b0;
      fd_q <= '0;
    end else begin
      fv_q <= serve;
      fd_q <= serve ? mem[fetch_addr] : '0;
    end
  end

  assign fetch_valid = fv_q;
  assign fetch_data  = fd_q;
  assign boot_done   = done_q;
  assign overflow    = ovf_q;
  assign load_count  = ptr_q;
  assign vec_ready   = (ptr_q >= CW'(VEC_WORDS));

endmodule

// File: rtl/prog_ram_loader_chk.sv
module prog_ram_loader_chk #(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          fetch_valid,
  input logic          boot_active,
  input logic          core_run,
  input logic          boot_done,
  input logic          overflow,
  input logic [CW-1:0] load_count
);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done);

  a_r7_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> (core_run && !boot_active));

  a_r8_no_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
    !core_run |=> !fetch_valid);

  a_r2_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_active) |-> (load_count == '0 && !overflow));

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_active && wr_valid && load_count < CW'(DEPTH)) |=>
      (load_count == $past(load_count) + 1'b1));

  a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> (overflow || boot_active));

  a_r4_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    load_count <= CW'(DEPTH));

  a_r5_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_active && !$rose(boot_active)) |=> ($stable(load_count) || boot_active));

endmodule

bind prog_ram_loader prog_ram_loader_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .fetch_valid(fetch_valid),
  .boot_active(boot_active), .core_run(core_run), .boot_done(boot_done),
  .overflow(overflow), .load_count(load_count)
);

// File: tb/tb_prog_ram_loader.sv
`timescale 1ns/1ps
module tb_prog_ram_loader;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, ctl_boot = 0, ctl_srst = 0, wr_valid = 0, fetch_req = 0;
  logic [23:0] wr_data = '0;
  logic [6:0]  fetch_addr = '0;
  logic        fetch_valid, boot_active, core_run, boot_done, vec_ready, overflow;
  logic [19:0] fetch_data;
  logic [7:0]  load_count;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [19:0] exp_q[$];

  always #2.5 clk = ~clk;

  prog_ram_loader dut (.*);

  function automatic logic [23:0] word_a(int i);
    return {4'hC ^ i[3:0], 20'(i * 20'h1357B + 20'h0F0F1)};
  endfunction
  function automatic logic [23:0] word_b(int i);
    return {4'h5, 20'(i * 20'h2C4D9 ^ 20'hA5A5A)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctl(bit b, bit s);
    @(negedge clk); ctl_we = 1; ctl_boot = b; ctl_srst = s;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic send(logic [23:0] w);
    @(negedge clk); wr_valid = 1; wr_data = w;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic fetch(int a, bit expect_it, logic [19:0] e);
    @(negedge clk); fetch_req = 1; fetch_addr = 7'(a);
    if (expect_it) exp_q.push_back(e);
    @(negedge clk); fetch_req = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && fetch_valid) begin
      logic [19:0] e;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8 unexpected fetch actual=%0h expected=none", fetch_data);
      end else begin
        e = exp_q.pop_front();
        if (fetch_data !== e) begin
          fails++;
          $display("FAIL R3 R9 fetch actual=%0h expected=%0h", fetch_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 core_run", core_run, 0);
    chk("R1 boot_active", boot_active, 0);
    chk("R1 boot_done", boot_done, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 fetch_valid", fetch_valid, 0);
    chk("R1 load_count", load_count, 0);

    send(24'hFFFFFF);
    chk("R5 count idle", load_count, 0);
    ctl(0, 1);
    chk("R2 hold only", boot_active, 0);
    ctl(1, 1);
    chk("R2 active", boot_active, 1);
    chk("R2 count zero", load_count, 0);

    for (int i = 0; i < 20; i++) begin
      send(word_a(i));
      if (i == 8) chk("R6 nine words", vec_ready, 0);
      if (i == 9) chk("R6 ten words", vec_ready, 1);
    end
    chk("R3 count", load_count, 20);

    fetch(0, 0, '0);
    chk("R8 valid held", fetch_valid, 0);
    chk("R8 data held", fetch_data, 0);

    ctl(1, 0);
    chk("R7 done pulse", boot_done, 1);
    chk("R7 core_run", core_run, 1);
    chk("R7 boot off", boot_active, 0);
    @(negedge clk);
    chk("R7 done single", boot_done, 0);

    for (int i = 0; i < 20; i++) fetch(i, 1, word_a(i)[19:0]);

    send(24'h123456); send(24'h0ABCDE);
    chk("R5 count running", load_count, 20);
    for (int i = 0; i < 3; i++) fetch(i, 1, word_a(i)[19:0]);

    ctl(1, 1);
    chk("R2 reentry count", load_count, 0);
    for (int i = 0; i < 130; i++) begin
      send(word_b(i));
      if (i == 127) begin
        chk("R4 full count", load_count, 128);
        chk("R4 not yet", overflow, 0);
      end
    end
    chk("R4 count capped", load_count, 128);
    chk("R4 overflow", overflow, 1);
    ctl(1, 0);
    chk("R4 sticky", overflow, 1);
    chk("R7 second done", boot_done, 1);
    fetch(0, 1, word_b(0)[19:0]);
    fetch(10, 1, word_b(10)[19:0]);
    fetch(19, 1, word_b(19)[19:0]);
    fetch(20, 1, word_b(20)[19:0]);
    fetch(127, 1, word_b(127)[19:0]);

    ctl(1, 1);
    chk("R4 cleared", overflow, 0);
    chk("R6 new load", vec_ready, 0);
    ctl(1, 0);
    ctl(0, 1);
    chk("R8 held again", core_run, 0);
    ctl(0, 0);
    chk("R7 no pulse", boot_done, 0);
    chk("R7 run again", core_run, 1);

    repeat (3) @(negedge clk);
    chk("R9 all served", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule